// File: doc/BRIEF.md
# Legacy Instruction Prefix Stripper

The block receives the bytes of one variable-length legacy instruction, one byte per cycle, lowest address first. It separates the leading prefix bytes from the rest of the instruction. For each prefix kind it sets a flag, and it counts the prefix bytes. The first non-prefix bytes, up to a parameterised limit, are packed little-endian into an opcode register. The block also produces a syndrome word that holds the prefix flags, the prefix count and a zero vector field. This word is meant for a trap handler that emulates intercepted instructions.

A start pulse opens each instruction. The sender then presents bytes with a valid flag and marks the final byte with a last flag. A one-cycle done strobe follows that final byte. The opcode and syndrome outputs then hold until the next start pulse.

Top module: `pfx_strip`

## Requirements
- R1: While no opcode byte has yet been accepted, a byte equal to 0xF3, 0xF2, 0xF0, 0x66, 0x67, 0x2E, 0x36, 0x3E, 0x26, 0x64 or 0x65 is a prefix and never appears in `opcode`.
- R2: The byte 0x0F is never a prefix. It is captured as an opcode byte.
- R3: The first opcode byte lands in `opcode[7:0]`, and each later byte lands in the next higher byte lane.
- R4: When the instruction ends with fewer than 8 opcode bytes, the unfilled upper lanes of `opcode` read zero.
- R5: Opcode bytes after the eighth are dropped and do not change `opcode`.
- R6: Syndrome mask bits, set once per kind: bit0 for 0xF3, bit1 for 0xF2, bit2 for 0xF0, bit3 for 0x66, bit4 for 0x67, bit5 for any of 0x2E/0x36/0x3E/0x26/0x64/0x65.
- R7: `syndrome[9:6]` counts the prefix bytes, including repeats, and saturates at 15.
- R8: Bits above 9 of `syndrome` are zero, and `vector` is always 0 (instruction intercept).
- R9: After the first opcode byte, a byte with a prefix value is captured as opcode data and leaves the mask and count unchanged.
- R10: `start` clears the opcode, the mask, the count and done.
- R11: `done` is high for exactly one cycle, the cycle after the byte marked `last` is accepted. The outputs then hold until the next `start`.
- R12: An instruction made only of prefix bytes reports an all-zero `opcode` and still reports its mask and count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begins a new instruction, clears the capture |
| in_valid | input | 1 | `in_byte` is valid this cycle |
| in_byte | input | 8 | Instruction byte, lowest address first |
| in_last | input | 1 | Marks the final byte of the instruction |
| opcode | output | 64 | Captured non-prefix bytes, little-endian |
| syndrome | output | 32 | {zero, count[9:6], mask[5:0]} |
| vector | output | 8 | Interruption vector, always 0 |
| done | output | 1 | One-cycle strobe after the last byte |

## Verification
The bench builds the block with its default parameters: an 8-byte capture and a 4-bit count. With these values, both the capture overflow beyond eight bytes and the count saturation at 15 are reached by short instructions. The stimulus covers prefix-only instructions, repeated prefixes, the 0x0F escape byte, prefix values that appear after the opcode starts, and back-to-back instructions that test clearing on start.

// File: rtl/pfx_strip.sv
module pfx_strip #(
  parameter int CAP_BYTES = 8,
  parameter int CNT_W     = 4,
  parameter int SYN_W     = 32
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   start,
  input  logic                   in_valid,
  input  logic [7:0]             in_byte,
  input  logic                   in_last,
  output logic [CAP_BYTES*8-1:0] opcode,
  output logic [SYN_W-1:0]       syndrome,
  output logic [7:0]             vector,
  output logic                   done
);
  localparam int IDX_W   = $clog2(CAP_BYTES + 1);
  localparam int MASK_W  = 6;
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [MASK_W-1:0] mask_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [IDX_W-1:0]  idx_q;
  logic              in_op_q;
  logic [CAP_BYTES*8-1:0] op_q;
  logic              done_q;

  logic [MASK_W-1:0] hit;
  always_comb begin
    hit = '0;
    case (in_byte)
      8'hF3: hit[0] = 1'b1;
      8'hF2: hit[1] = 1'b1;
      8'hF0: hit[2] = 1'b1;
      8'h66: hit[3] = 1'b1;
      8'h67: hit[4] = 1'b1;
      8'h2E, 8'h36, 8'h3E, 8'h26, 8'h64, 8'h65: hit[5] = 1'b1;
      default: hit = '0;
    endcase
  end

  wire is_pfx  = (|hit) && !in_op_q;
  wire take    = in_valid && !start;
  wire has_room = idx_q < IDX_W'(CAP_BYTES);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q  <= '0;
      cnt_q   <= '0;
      idx_q   <= '0;
      in_op_q <= 1'b0;
      op_q    <= '0;
      done_q  <= 1'b0;
    end else if (start) begin
      mask_q  <= '0;
      cnt_q   <= '0;
      idx_q   <= '0;
      in_op_q <= 1'b0;
      op_q    <= '0;
      done_q  <= 1'b0;
    end else begin
      done_q <= take && in_last;
      if (take) begin
        if (is_pfx) begin
          mask_q <= mask_q | hit;
          if (cnt_q != CNT_MAX) cnt_q <= cnt_q + 1'b1;
        end else begin
          in_op_q <= 1'b1;
          if (has_room) begin
            op_q[idx_q*8 +: 8] <= in_byte;
            idx_q <= idx_q + 1'b1;
          end
        end
      end
    end
  end

  assign opcode   = op_q;
  assign syndrome = {{(SYN_W-MASK_W-CNT_W){1'b0}}, cnt_q, mask_q};
  assign vector   = 8'd0;
  assign done     = done_q;

  a_r11_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done || $past(in_valid && in_last));
  a_r10_start_clears: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (opcode == '0) && (syndrome == '0) && !done);
  a_r7_count_sat: assert property (@(posedge clk) disable iff (!rst_n)
    (syndrome[9:6] == 4'hF) && !$past(start) |=> syndrome[9:6] == 4'hF || $past(start));
  a_r9_mask_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    in_op_q && !start |=> $stable(syndrome));
  a_r5_full_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (idx_q == IDX_W'(CAP_BYTES)) && !start |=> $stable(opcode));
  a_r8_zero_vec: assert property (@(posedge clk) disable iff (!rst_n)
    vector == 8'd0 && syndrome[SYN_W-1:10] == '0);
endmodule

// File: tb/pfx_strip_bench.sv
module pfx_strip_bench;
  logic clk = 0, rst_n = 0, start = 0, in_valid = 0, in_last = 0;
  logic [7:0] in_byte = 0;
  logic [63:0] opcode;
  logic [31:0] syndrome;
  logic [7:0] vector;
  logic done;
  int checks = 0, fails = 0;
  bit finished = 0;

  typedef struct { logic [63:0] op; logic [31:0] syn; string tag; } exp_t;
  exp_t q[$];

  always #4 clk = ~clk;

  pfx_strip u_pfx_strip (.clk, .rst_n, .start, .in_valid, .in_byte, .in_last,
                         .opcode, .syndrome, .vector, .done);

  task automatic chk(string tag, logic [95:0] act, logic [95:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic bit is_p(logic [7:0] b);
    return b inside {8'hF3,8'hF2,8'hF0,8'h66,8'h67,8'h2E,8'h36,8'h3E,8'h26,8'h64,8'h65};
  endfunction
  function automatic logic [5:0] pbit(logic [7:0] b);
    case (b)
      8'hF3: return 6'd1;  8'hF2: return 6'd2;  8'hF0: return 6'd4;
      8'h66: return 6'd8;  8'h67: return 6'd16; default: return 6'd32;
    endcase
  endfunction

  task automatic send(string tag, logic [7:0] bytes[$]);
    exp_t e; logic [5:0] m = 0; int c = 0, n = 0; bit op = 0;
    e.op = 0;
    foreach (bytes[i]) begin
      if (!op && is_p(bytes[i])) begin m |= pbit(bytes[i]); if (c < 15) c++; end
      else begin op = 1; if (n < 8) begin e.op[n*8 +: 8] = bytes[i]; n++; end end
    end
    e.syn = {22'd0, 4'(c), m};
    e.tag = tag;
    q.push_back(e);
    @(negedge clk); start = 1;
    @(negedge clk); start = 0;
    chk({tag, " R10 cleared"}, {opcode, syndrome}, 96'd0);
    foreach (bytes[i]) begin
      in_valid = 1; in_byte = bytes[i]; in_last = (i == bytes.size()-1);
      @(negedge clk);
    end
    in_valid = 0; in_last = 0;
    repeat (3) @(negedge clk);
    chk({tag, " R11 hold"}, {opcode, syndrome}, {e.op, e.syn});
  endtask

  initial begin : monitor
    exp_t e;
    forever begin
      @(negedge clk);
      if (done) begin
        if (q.size() == 0) begin checks++; fails++; $display("FAIL R11 unexpected done act=1 exp=0"); end
        else begin
          e = q.pop_front();
          chk({e.tag, " opcode R1 R3 R4"}, {32'd0, opcode}, {32'd0, e.op});
          chk({e.tag, " syndrome R6 R7"}, {64'd0, syndrome}, {64'd0, e.syn});
          chk({e.tag, " R8 vector"}, {88'd0, vector}, 96'd0);
          @(negedge clk);
          chk({e.tag, " R11 one-cycle done"}, {95'd0, done}, 96'd0);
        end
      end
    end
  end

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++; fails++; $display("FAIL watchdog act=hung exp=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R10 reset state", {opcode, syndrome}, 96'd0);
    chk("R8 reset vector", {88'd0, vector, 31'd0, done} >> 0, 96'd0);
    rst_n = 1;
    send("R1 R3 basic", '{8'h66, 8'hF0, 8'h89, 8'h45, 8'h08});
    send("R2 escape", '{8'h0F, 8'h01, 8'hD8});
    send("R6 segments", '{8'h2E, 8'h65, 8'h26, 8'hF3, 8'h90});
    send("R5 long", '{8'h67, 8'h11,8'h22,8'h33,8'h44,8'h55,8'h66,8'h77,8'h88,8'h99,8'hAA});
    send("R9 late prefix", '{8'h0F, 8'hF3, 8'h66, 8'h2E});
    send("R7 saturate", '{8'hF2,8'hF2,8'hF2,8'hF2,8'hF2,8'hF2,8'hF2,8'hF2,
                          8'hF2,8'hF2,8'hF2,8'hF2,8'hF2,8'hF2,8'hF2,8'hF2,8'hF2,8'hC3});
    send("R12 prefix only", '{8'h66, 8'h67, 8'h66});
    send("R4 single", '{8'hC3});
    repeat (4) @(negedge clk);
    chk("R11 queue drained", {64'd0, 32'(q.size())}, 96'd0);
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule